// File: doc/BRIEF.md
# Corner-Turning Row I/O Shifter

This block is the background I/O path of a bit-serial processor array. Each processing unit owns a bit-wide local memory and an 8-bit I/O register. The block gathers one row of bytes into those registers by reading eight consecutive bit-planes, one plane per granted access. Plane `base+k` supplies bit k of every unit's byte, so the registers end up holding whole bytes. This is the corner turn.

The registers are then joined into one chain, with unit 0 at the west end. The chain moves one byte east on every clock in which the streaming input offers a byte. Each such step emits the byte held by the east-most unit and takes in the offered byte at the west end. After one step per unit, the outgoing row has left the array and the incoming row fills the registers. The block then writes the new row back to the same eight planes and pulses `done`.

Memory is touched only during the load and store phases, and only through a request/grant handshake. The processors can therefore keep working while the row streams.

The sequencer has four states. IDLE goes to LOAD on `start`. LOAD goes to SHIFT on the grant of its last plane. SHIFT goes to STORE on the last accepted byte. STORE goes back to IDLE on the grant of its last plane and raises `done` in the following cycle. Within LOAD and STORE, a denied request keeps the same plane. Within SHIFT, a cycle without `in_valid` keeps the same step.

Top module: `plane_row_streamer`

## Requirements
- R1: After reset, `done`, `mem_req` and `out_valid` are all 0.
- R2: A `start` sampled in IDLE makes the block request a read in the next cycle, with `mem_we`=0 and `mem_addr` equal to the captured `base_addr`.
- R3: LOAD makes eight granted reads at `base_addr+k` for k=0..7 in ascending order, wrapping modulo 2^ADDR_W. An ungranted request holds its address. On the grant of plane k, bit k of unit u's register takes `mem_rdata[u]`.
- R4: During SHIFT, `mem_req` stays 0. The block produces exactly UNITS output bytes per row.
- R5: The j-th output byte of a row (counting from 0) is the byte that LOAD assembled for unit UNITS-1-j. Unit u corresponds to memory data bit u, and unit 0 is the west end.
- R6: The j-th accepted input byte ends up in unit UNITS-1-j.
- R7: STORE makes eight granted writes at `base_addr+k` for k=0..7, wrapping modulo 2^ADDR_W. Each write drives `mem_wdata[u]` with bit k of unit u's byte.
- R8: `done` is a single-cycle pulse in the cycle after the last store grant. At that point the block is idle and accepts the next `start`.
- R9: A `start` or a changed `base_addr` while a row is in progress has no effect on that row.
- R10: `out_valid` is high only in SHIFT cycles with `in_valid` high. A cycle with `in_valid` low holds the chain. Outside SHIFT, `in_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row transfer (taken in IDLE only) |
| base_addr | input | ADDR_W | First bit-plane address of the row |
| done | output | 1 | One-cycle pulse at the end of the row |
| mem_req | output | 1 | Bit-plane access request |
| mem_we | output | 1 | 1 = write plane, 0 = read plane |
| mem_addr | output | ADDR_W | Bit-plane address |
| mem_wdata | output | UNITS | Plane written, bit u from unit u |
| mem_rdata | input | UNITS | Plane read, valid in the grant cycle |
| mem_gnt | input | 1 | Grant of the current request |
| in_byte | input | BYTE_W | Byte entering at the west end |
| in_valid | input | 1 | `in_byte` offered this cycle |
| out_byte | output | BYTE_W | Byte leaving at the east end |
| out_valid | output | 1 | `out_byte` taken this cycle |

## Verification
Rows are run back to back over a sweep of base addresses, including one that wraps the plane address. Grants arrive in three patterns: always, alternate cycles, and pseudo-random. Input bytes are offered continuously, with regular gaps, and pseudo-randomly. The memory holds an arithmetic pattern, so each plane differs from its neighbours. A wrong plane order, a swapped bit within a byte, or a reversed unit order therefore each give a visible mismatch in the emitted bytes or in the stored planes. The denied grants and input gaps separate a design that advances on its own from one that waits for its handshakes. A `start` with a different base injected mid-row shows whether a busy row can be disturbed.

// File: rtl/plane_row_pkg.sv
package plane_row_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STORE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/plane_row_lane.sv
module plane_row_lane #(
    parameter int BYTE_W = 8,
    localparam int PL_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [PL_W-1:0]   plane_idx,
    input  logic              plane_bit,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] west_byte,
    output logic [BYTE_W-1:0] byte_q,
    output logic              plane_out
);
    // One unit's I/O register: bit-plane writes during load, whole-byte moves during shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load_en) begin
            byte_q[plane_idx] <= plane_bit;
        end else if (shift_en) begin
            byte_q <= west_byte;
        end
    end

    assign plane_out = byte_q[plane_idx];

    // R3: a granted plane read lands in the selected bit
    a_r3_plane_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> byte_q[$past(plane_idx)] == $past(plane_bit));

    // R6: a shift step takes the west neighbour's byte
    a_r6_shift_take: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> byte_q == $past(west_byte));

    // R4: the load and shift phases never overlap
    a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && shift_en));
endmodule

// File: rtl/plane_row_seq.sv
module plane_row_seq
    import plane_row_pkg::*;
#(
    parameter int UNITS  = 8,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10,
    localparam int PL_W   = $clog2(BYTE_W),
    localparam int STEP_W = $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mem_gnt,
    input  logic              in_valid,
    output logic [PL_W-1:0]   plane_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              load_en,
    output logic              shift_en,
    output logic              out_valid,
    output logic              done
);
    localparam logic [PL_W-1:0]   PLANE_LAST = PL_W'(BYTE_W - 1);
    localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(UNITS - 1);

    seq_state_e        state_q, state_d;
    logic [PL_W-1:0]   plane_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] base_q;
    logic              done_q;
    logic              plane_adv, step_adv, done_set;
    logic              plane_last, step_last;

    assign plane_last = (plane_q == PLANE_LAST);
    assign step_last  = (step_q == STEP_LAST);

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            plane_q <= '0;
            step_q  <= '0;
            base_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_set;
            if (state_q == ST_IDLE && start) begin
                base_q <= base_addr;
            end
            if (plane_adv) begin
                plane_q <= plane_last ? '0 : plane_q + 1'b1;
            end
            if (step_adv) begin
                step_q <= step_last ? '0 : step_q + 1'b1;
            end
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d   = state_q;
        plane_adv = 1'b0;
        step_adv  = 1'b0;
        done_set  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        load_en   = 1'b0;
        shift_en  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    load_en   = 1'b1;
                    plane_adv = 1'b1;
                    if (plane_last) state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (in_valid) begin
                    shift_en  = 1'b1;
                    out_valid = 1'b1;
                    step_adv  = 1'b1;
                    if (step_last) state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_gnt) begin
                    plane_adv = 1'b1;
                    if (plane_last) begin
                        state_d  = ST_IDLE;
                        done_set = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign plane_idx = plane_q;
    assign mem_addr  = base_q + ADDR_W'(plane_q);
    assign done      = done_q;

    // R4: no memory traffic while the row streams
    a_r4_no_mem_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> !mem_req);

    // R3: a denied request keeps its address and stays raised
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows a store grant
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we && mem_gnt));

    // R10: output only when a byte is offered
    a_r10_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);

    // R9: the captured base stays put while a row is busy
    a_r9_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(base_q));
endmodule

// File: rtl/plane_row_streamer.sv
module plane_row_streamer #(
    parameter int UNITS  = 8,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [UNITS-1:0]  mem_wdata,
    input  logic [UNITS-1:0]  mem_rdata,
    input  logic              mem_gnt,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid
);
    localparam int PL_W = $clog2(BYTE_W);

    logic [PL_W-1:0]   plane_idx;
    logic              load_en, shift_en;
    logic [BYTE_W-1:0] chain [UNITS];

    plane_row_seq #(
        .UNITS  (UNITS),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .mem_gnt   (mem_gnt),
        .in_valid  (in_valid),
        .plane_idx (plane_idx),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .out_valid (out_valid),
        .done      (done)
    );

    // Unit 0 is the west end; each unit takes its byte from its west neighbour
    for (genvar u = 0; u < UNITS; u++) begin : g_lane
        logic [BYTE_W-1:0] west;
        if (u == 0) begin : g_edge
            assign west = in_byte;
        end else begin : g_inner
            assign west = chain[u-1];
        end
        plane_row_lane #(
            .BYTE_W (BYTE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en),
            .plane_idx (plane_idx),
            .plane_bit (mem_rdata[u]),
            .shift_en  (shift_en),
            .west_byte (west),
            .byte_q    (chain[u]),
            .plane_out (mem_wdata[u])
        );
    end

    assign out_byte = chain[UNITS-1];

    // R1: quiet interface right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_req && !out_valid));

    // R5: the emitted byte is what the east unit held
    a_r5_east_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> chain[UNITS-1] == $past(chain[UNITS-2]));
endmodule

// File: tb/plane_row_streamer_bench.sv
`timescale 1ns/1ps
module plane_row_streamer_bench;
    localparam int UNITS  = 4;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              done, mem_req, mem_we, out_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [UNITS-1:0]  mem_wdata, mem_rdata;
    logic              mem_gnt = 1'b0;
    logic [BYTE_W-1:0] in_byte = '0, out_byte;
    logic              in_valid = 1'b0;

    always #2 clk = ~clk;

    plane_row_streamer #(.UNITS(UNITS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_plane_row_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .in_byte(in_byte), .in_valid(in_valid),
        .out_byte(out_byte), .out_valid(out_valid)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [UNITS-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] row_base = '0;
    int go_cnt = 0, go_seen = 0, done_cnt = 0;
    int gmode = 0, vmode = 0;
    bit poke_en = 0, poked = 0, fresh = 0, last_store = 0, live = 0;
    logic [BYTE_W-1:0] in_q [UNITS];
    logic [BYTE_W-1:0] out_got [UNITS];
    int in_idx = 0, out_cnt = 0, ld_idx = 0, st_idx = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_gnt) mem[mem_addr] <= mem_wdata;
    end

    // Driver and monitor: drive at the falling edge, sample 1 ns later
    always @(negedge clk) begin
        bit fresh_chk;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fresh_chk = fresh;
        fresh = 0;
        if (go_cnt != go_seen) begin
            start = 1'b1; base_addr = row_base; go_seen = go_cnt; fresh = 1;
        end else if (poke_en && !poked && out_cnt == 1) begin
            start = 1'b1; base_addr = row_base + 6'd7; poked = 1;
        end else begin
            start = 1'b0; base_addr = ~row_base;
        end
        mem_gnt  = (gmode == 0) ? 1'b1 : (gmode == 1) ? cyc[0] : lfsr[0];
        in_valid = (vmode == 0) ? 1'b1 : (vmode == 1) ? (cyc % 3 != 0) : lfsr[3];
        in_byte  = (in_idx < UNITS) ? in_q[in_idx] : BYTE_W'(cyc * 7);
        #1;
        if (live) begin
            if (fresh_chk)
                chk(mem_req && !mem_we && mem_addr == row_base, "R2", "first read", int'(mem_addr), int'(row_base));
            if (last_store || done)
                chk(done == last_store, "R8", "done pulse", int'(done), int'(last_store));
            if (done) done_cnt++;
            last_store = 0;
            if (mem_req && mem_gnt) begin
                if (ld_idx < BYTE_W) begin
                    chk(!mem_we && mem_addr == ADDR_W'(row_base + ld_idx), "R3", "read addr", int'(mem_addr), int'(ADDR_W'(row_base + ld_idx)));
                    ld_idx++;
                end else begin
                    chk(mem_we && mem_addr == ADDR_W'(row_base + st_idx), "R7", "write addr", int'(mem_addr), int'(ADDR_W'(row_base + st_idx)));
                    st_idx++;
                    if (st_idx == BYTE_W) last_store = 1;
                end
            end
            if (out_valid && mem_req) chk(0, "R4", "req during shift", 1, 0);
            if (out_valid && !in_valid) chk(0, "R10", "out without in", 1, 0);
            if (in_valid && out_valid) begin
                if (out_cnt < UNITS) out_got[out_cnt] = out_byte;
                out_cnt++;
                in_idx++;
            end
        end
        if (cyc > 60000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 60000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run_row(input int base, input int gm, input int vm, input bit poke, input int seed);
        logic [BYTE_W-1:0] exp_load [UNITS];
        int d0, t;
        row_base = ADDR_W'(base); gmode = gm; vmode = vm; poke_en = poke; poked = 0;
        ld_idx = 0; st_idx = 0; out_cnt = 0; in_idx = 0;
        for (int u = 0; u < UNITS; u++) begin
            in_q[u] = BYTE_W'(seed * 37 + u * 11 + 5);
            for (int k = 0; k < BYTE_W; k++) exp_load[u][k] = mem[ADDR_W'(base + k)][u];
        end
        d0 = done_cnt;
        go_cnt++;
        t = 0;
        while (done_cnt == d0 && t < 4000) begin @(negedge clk); t++; end
        #2;
        chk(out_cnt == UNITS, "R4", "output count", out_cnt, UNITS);
        chk(ld_idx == BYTE_W && st_idx == BYTE_W, "R8", "grant count", ld_idx + st_idx, 2 * BYTE_W);
        for (int j = 0; j < UNITS; j++)
            chk(out_got[j] == exp_load[UNITS-1-j], "R5", "out byte", int'(out_got[j]), int'(exp_load[UNITS-1-j]));
        for (int k = 0; k < BYTE_W; k++)
            for (int u = 0; u < UNITS; u++)
                chk(mem[ADDR_W'(base + k)][u] == in_q[UNITS-1-u][k], "R6", "stored bit",
                    int'(mem[ADDR_W'(base + k)][u]), int'(in_q[UNITS-1-u][k]));
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = UNITS'(a * 5 + 3);
        repeat (3) @(negedge clk);
        #1;
        chk(!done && !mem_req && !out_valid, "R1", "reset outputs", {done, mem_req, out_valid}, 0);
        rst_n = 1'b1;
        live = 1;
        repeat (2) @(negedge clk);
        #2;
        chk(!done && !mem_req && !out_valid, "R1", "idle outputs", {done, mem_req, out_valid}, 0);
        // Sweep of bases, grant patterns and input gap patterns; R9 start poke on some rows
        run_row(0, 0, 0, 0, 1);
        run_row(61, 1, 1, 0, 2);
        for (int r = 0; r < 9; r++)
            run_row((r * 13 + 5) % DEPTH, r % 3, (r / 3) % 3, (r % 4 == 2), r + 3);
        run_row(60, 2, 2, 1, 17);
        // R10: after a row, offered input bytes produce nothing
        vmode = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk(!out_valid && !mem_req, "R10", "idle ignores input", {out_valid, mem_req}, 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule